// File: doc/BRIEF.md
# Transfer Counter and DMA Completion Engine

This block runs the transfer-information step of a parallel-bus storage controller. Two byte registers hold a programmed transfer count. When a transfer command arrives the block forms the 16-bit count, where zero stands for 65536 bytes. It clamps that count to a fixed limit while command bytes are being gathered. Otherwise it clamps the count to the size of the data the target still has pending. The sign of that pending size gives the direction of the transfer.

The block then drives a memory mover through a request/acknowledge pair, one chunk at a time. A chunk never exceeds what the device side has offered. When the remaining length reaches zero, the block posts completion status, a bus-service reason and an interrupt.

It also gates selection commands on a DMA-enable pin. When the selected target is absent it reports a disconnect. When the target is present, or when a gathered command is issued, it loads the target's pending size and reports the phase that will follow.

Top module: `xfer_ctl`

## Requirements
- R1: The count is `{tc_mid, tc_lo}`; a value of zero means 65536 bytes, so a data transfer with count zero and pending size -70000 asks for a 65536-byte chunk.
- R2: A DMA transfer command in command mode asks for min(count, CMD_MAX) bytes (CMD_MAX = 32), with `dma_to_dev` = 1 (memory read) and `dma_offset` equal to `cmd_len` at the start.
- R3: A DMA transfer command in data mode sets the remaining length to min(count, |pend_size|); `dma_to_dev` is 1 when `pend_size` is negative and 0 when it is positive.
- R4: A DMA transfer command clears status bit 4 on the next edge. A transfer command with both `dma_mode` and `cmd_mode` low changes nothing: no request, status kept, pending size kept.
- R5: Each chunk is min(remaining, bytes offered and not yet moved). With nothing offered no request is raised, and completion waits until the remaining length is zero. The request and its length stay stable until acknowledged.
- R6: Each acknowledged chunk moves `pend_size` toward zero by the chunk length.
- R7: Completion sets status bit 4, sets the reason to 0x10, the sequence step to 0 and `irq` to 1, and pulses `tc_clear` in the acknowledge cycle.
- R8: A command issue comes either from acknowledging the command-mode DMA request or from a command-mode transfer command without DMA. It pulses `cmd_issue` in that cycle and then reports the same way a successful selection does.
- R9: A selection issued while `dma_en` is low does nothing until `dma_en` is high, and it then runs on that edge.
- R10: A selection of a present target loads `pend_size` from `pend_val` and sets the reason to 0x18, the step to 4 and `irq` to 1. If `pend_val` is nonzero, status bits 6:0 become 0x11 for a positive value (data in) or 0x10 for a negative value (data out). If it is zero, they are kept.
- R11: A selection of a target whose `tgt_present` bit (indexed by `bus_id`) is 0 sets status bits 6:0 to 0, the reason to 0x20, the step to 0 and `irq` to 1.
- R12: After reset, `status`, `intr_reason`, `seq_step`, `pend_size`, `irq` and `dma_req` are all 0. Status bit 7 always equals `irq`.
- R13: A DMA data transfer whose clamped length is zero completes at once without raising a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tc_lo | input | 8 | Transfer count, low byte |
| tc_mid | input | 8 | Transfer count, high byte |
| ti_start | input | 1 | Transfer-information command pulse |
| dma_mode | input | 1 | Command uses DMA |
| cmd_mode | input | 1 | Command bytes are being gathered |
| cmd_len | input | OFS_W | Command bytes already held |
| bus_id | input | ID_W | Selected target ID |
| tgt_present | input | NUM_TGT | One bit per target that answers |
| sel_start | input | 1 | Selection command pulse |
| dma_en | input | 1 | DMA-enable pin |
| pend_val | input | 18 | Signed data size reported by the target at command issue |
| dev_offer | input | 1 | Device side offers bytes |
| dev_bytes | input | 17 | Number of bytes offered |
| dma_ack | input | 1 | Memory mover finished the chunk |
| dma_req | output | 1 | Chunk request to memory mover |
| dma_len | output | 17 | Chunk length |
| dma_to_dev | output | 1 | 1: memory read toward device, 0: memory write |
| dma_offset | output | OFS_W | Command-buffer offset of the chunk |
| cmd_issue | output | 1 | Command issued; gathering ends |
| tc_clear | output | 1 | Zero both count bytes |
| pend_size | output | 18 | Signed pending size |
| status | output | 8 | Status; bit 7 mirrors irq, bit 4 terminal count |
| intr_reason | output | 8 | Interrupt reason |
| seq_step | output | 3 | Sequence step |
| irq | output | 1 | Interrupt |

## Verification
Some behaviours are checked by assertions on every cycle. A pending request holds its length until it is acknowledged. A chunk never exceeds the remaining length and is never empty. Each acknowledge shrinks the pending magnitude by exactly the chunk. A command-mode request always reads memory within the limit. No selection outcome appears while `dma_en` is low. Completion and disconnect leave their exact reason and step codes.

Other behaviours only the directed scenarios can show. These are the 65536 meaning of a zero count, the two clamps with their chosen directions, and the wait for further device offers. They also cover the deferred selection firing when the pin rises, the silent transfer command without DMA, and immediate completion for a zero length.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_MOVE = 2'd2,
    ST_CMD  = 2'd3
  } dma_st_e;

  localparam logic [6:0] STAT_TC   = 7'h10;
  localparam logic [6:0] PH_DIN    = 7'h01;
  localparam logic [6:0] PH_DOUT   = 7'h00;
  localparam logic [7:0] RSN_BUS   = 8'h10;
  localparam logic [7:0] RSN_SEL   = 8'h18;
  localparam logic [7:0] RSN_DISC  = 8'h20;
  localparam logic [2:0] SEQ_CMD   = 3'd4;
  localparam logic [2:0] SEQ_ZERO  = 3'd0;
endpackage

// File: rtl/xfer_clamp.sv
module xfer_clamp #(
  parameter int CNT_W   = 16,
  parameter int CMD_MAX = 32,
  parameter int LEN_W   = CNT_W + 1,
  parameter int PEND_W  = LEN_W + 1
) (
  input  logic [CNT_W-1:0]         cnt_raw,
  input  logic                     cmd_mode,
  input  logic signed [PEND_W-1:0] pend,
  output logic [LEN_W-1:0]         len,
  output logic                     to_dev
);
  logic [PEND_W-1:0] count_w, mag_w, lim_w, min_w;

  always_comb begin
    // zero programmed count stands for a full 2^CNT_W bytes
    count_w = (cnt_raw == '0) ? (PEND_W'(1) << CNT_W) : PEND_W'(cnt_raw);
    mag_w   = pend[PEND_W-1] ? PEND_W'(-pend) : PEND_W'(pend);
    lim_w   = cmd_mode ? PEND_W'(CMD_MAX) : mag_w;
    min_w   = (count_w < lim_w) ? count_w : lim_w;
    len     = LEN_W'(min_w);
    to_dev  = pend[PEND_W-1];
  end
endmodule

// File: rtl/xfer_dma_seq.sv
module xfer_dma_seq
  import xfer_pkg::*;
#(
  parameter int LEN_W   = 17,
  parameter int PEND_W  = LEN_W + 1,
  parameter int CMD_MAX = 32,
  parameter int OFS_W   = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ti_start,
  input  logic                     dma_mode,
  input  logic                     cmd_mode,
  input  logic [LEN_W-1:0]         clamp_len,
  input  logic                     clamp_to_dev,
  input  logic [OFS_W-1:0]         cmd_len,
  input  logic                     dev_offer,
  input  logic [LEN_W-1:0]         dev_bytes,
  input  logic                     dma_ack,
  input  logic                     pend_load,
  input  logic signed [PEND_W-1:0] pend_val,
  output logic                     dma_req,
  output logic [LEN_W-1:0]         dma_len,
  output logic                     dma_to_dev,
  output logic [OFS_W-1:0]         dma_offset,
  output logic signed [PEND_W-1:0] pend_q,
  output logic                     ev_done,
  output logic                     ev_cmd_issue,
  output logic                     ev_ti_dma
);
  dma_st_e                  st_q, st_n;
  logic [LEN_W-1:0]         remain_q, remain_n;
  logic [LEN_W-1:0]         chunk_q, chunk_n;
  logic [PEND_W-1:0]        avail_q, avail_n;
  logic signed [PEND_W-1:0] pend_n;
  logic                     dir_q, dir_n;
  logic [OFS_W-1:0]         ofs_q, ofs_n;
  logic                     upd_en;
  logic [PEND_W-1:0]        pend_mag;

  assign ev_ti_dma = ti_start & dma_mode & (st_q == ST_IDLE);

  always_comb begin
    st_n         = st_q;
    remain_n     = remain_q;
    chunk_n      = chunk_q;
    dir_n        = dir_q;
    ofs_n        = ofs_q;
    pend_n       = pend_q;
    avail_n      = avail_q + (dev_offer ? PEND_W'(dev_bytes) : '0);
    ev_done      = 1'b0;
    ev_cmd_issue = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (ti_start) begin
          if (dma_mode && cmd_mode) begin
            chunk_n = clamp_len;
            dir_n   = 1'b1;
            ofs_n   = cmd_len;
            st_n    = ST_CMD;
          end else if (dma_mode) begin
            remain_n = clamp_len;
            dir_n    = clamp_to_dev;
            if (clamp_len == '0) ev_done = 1'b1;
            else                 st_n    = ST_WAIT;
          end else if (cmd_mode) begin
            ev_cmd_issue = 1'b1;
          end
        end
      end
      ST_WAIT: begin
        if (avail_q != '0) begin
          chunk_n = (PEND_W'(remain_q) < avail_q) ? remain_q : LEN_W'(avail_q);
          st_n    = ST_MOVE;
        end
      end
      ST_MOVE: begin
        if (dma_ack) begin
          remain_n = remain_q - chunk_q;
          avail_n  = avail_n - PEND_W'(chunk_q);
          pend_n   = dir_q ? pend_q + $signed({1'b0, chunk_q})
                           : pend_q - $signed({1'b0, chunk_q});
          if (remain_q == chunk_q) begin
            ev_done = 1'b1;
            st_n    = ST_IDLE;
          end else begin
            st_n    = ST_WAIT;
          end
        end
      end
      ST_CMD: begin
        if (dma_ack) begin
          ev_cmd_issue = 1'b1;
          st_n         = ST_IDLE;
        end
      end
      default: st_n = ST_IDLE;
    endcase
    if (pend_load) begin
      pend_n  = pend_val;
      avail_n = '0;
    end
  end

  assign upd_en = ti_start | dev_offer | dma_ack | pend_load | (st_q == ST_WAIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      remain_q <= '0;
      chunk_q  <= '0;
      avail_q  <= '0;
      pend_q   <= '0;
      dir_q    <= 1'b0;
      ofs_q    <= '0;
    end else if (upd_en) begin
      st_q     <= st_n;
      remain_q <= remain_n;
      chunk_q  <= chunk_n;
      avail_q  <= avail_n;
      pend_q   <= pend_n;
      dir_q    <= dir_n;
      ofs_q    <= ofs_n;
    end
  end

  assign dma_req    = (st_q == ST_MOVE) || (st_q == ST_CMD);
  assign dma_len    = chunk_q;
  assign dma_to_dev = dir_q;
  assign dma_offset = ofs_q;
  assign pend_mag   = pend_q[PEND_W-1] ? PEND_W'(-pend_q) : PEND_W'(pend_q);

  // R5: a raised request keeps its length until acknowledged
  assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && !dma_ack) |=> (dma_req && $stable(dma_len)));

  // R5: a data chunk is nonempty and never exceeds what remains
  assert_chunk_fits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_MOVE) |-> ((chunk_q != '0) && (chunk_q <= remain_q)));

  // R6: each acknowledged chunk shrinks the pending magnitude by the chunk
  assert_pend_shrink_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_MOVE && dma_ack && !pend_load) |=>
      (pend_mag == $past(pend_mag) - PEND_W'($past(chunk_q))));

  // R2: command gathering always reads memory within the limit
  assert_cmd_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_CMD) |-> (dma_to_dev && (dma_len <= LEN_W'(CMD_MAX))));
endmodule

// File: rtl/xfer_sel_gate.sv
module xfer_sel_gate #(
  parameter int NUM_TGT = 8,
  parameter int ID_W    = (NUM_TGT > 1) ? $clog2(NUM_TGT) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sel_start,
  input  logic               dma_en,
  input  logic [ID_W-1:0]    bus_id,
  input  logic [NUM_TGT-1:0] tgt_present,
  output logic               ev_sel_ok,
  output logic               ev_sel_absent
);
  logic hold_q, hold_n, run, hit;
  logic [NUM_TGT-1:0] id_match;

  for (genvar g = 0; g < NUM_TGT; g++) begin : g_match
    assign id_match[g] = (bus_id == ID_W'(g)) & tgt_present[g];
  end

  always_comb begin
    hit    = |id_match;
    run    = dma_en & (sel_start | hold_q);
    hold_n = (hold_q | sel_start) & ~dma_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  hold_q <= 1'b0;
    else if (sel_start | hold_q) hold_q <= hold_n;
  end

  assign ev_sel_ok     = run & hit;
  assign ev_sel_absent = run & ~hit;
endmodule

// File: rtl/xfer_status.sv
module xfer_status
  import xfer_pkg::*;
#(
  parameter int PEND_W = 18
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ev_ti_dma,
  input  logic                     ev_absent,
  input  logic                     ev_issue,
  input  logic signed [PEND_W-1:0] issue_val,
  input  logic                     ev_done,
  output logic [7:0]               status,
  output logic [7:0]               intr_reason,
  output logic [2:0]               seq_step,
  output logic                     irq
);
  logic [6:0] stat_q, stat_n;
  logic [7:0] rsn_q, rsn_n;
  logic [2:0] seq_q, seq_n;
  logic       irq_q, irq_n;
  logic       upd_en;

  always_comb begin
    stat_n = stat_q;
    rsn_n  = rsn_q;
    seq_n  = seq_q;
    irq_n  = irq_q;
    if (ev_ti_dma) stat_n[4] = 1'b0;
    if (ev_absent) begin
      stat_n = '0;
      rsn_n  = RSN_DISC;
      seq_n  = SEQ_ZERO;
      irq_n  = 1'b1;
    end
    if (ev_issue) begin
      if (issue_val != '0)
        stat_n = STAT_TC | (issue_val[PEND_W-1] ? PH_DOUT : PH_DIN);
      rsn_n = RSN_SEL;
      seq_n = SEQ_CMD;
      irq_n = 1'b1;
    end
    if (ev_done) begin
      stat_n[4] = 1'b1;
      rsn_n     = RSN_BUS;
      seq_n     = SEQ_ZERO;
      irq_n     = 1'b1;
    end
  end

  assign upd_en = ev_ti_dma | ev_absent | ev_issue | ev_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      rsn_q  <= '0;
      seq_q  <= '0;
      irq_q  <= 1'b0;
    end else if (upd_en) begin
      stat_q <= stat_n;
      rsn_q  <= rsn_n;
      seq_q  <= seq_n;
      irq_q  <= irq_n;
    end
  end

  assign status      = {irq_q, stat_q};
  assign intr_reason = rsn_q;
  assign seq_step    = seq_q;
  assign irq         = irq_q;

  // R7: completion leaves terminal count, bus-service reason, step 0, irq
  assert_done_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_done |=> (irq && status[4] && intr_reason == RSN_BUS && seq_step == SEQ_ZERO));

  // R11: absent target leaves disconnect reason and cleared status
  assert_absent_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_absent && !ev_issue && !ev_done) |=>
      (intr_reason == RSN_DISC && status[6:0] == 7'h00 && seq_step == SEQ_ZERO && irq));
endmodule

// File: rtl/xfer_ctl.sv
module xfer_ctl
  import xfer_pkg::*;
#(
  parameter int CMD_MAX = 32,
  parameter int NUM_TGT = 8,
  parameter int OFS_W   = 6,
  localparam int CNT_W  = 2 * BYTE_W,
  localparam int LEN_W  = CNT_W + 1,
  localparam int PEND_W = LEN_W + 1,
  localparam int ID_W   = (NUM_TGT > 1) ? $clog2(NUM_TGT) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [BYTE_W-1:0]        tc_lo,
  input  logic [BYTE_W-1:0]        tc_mid,
  input  logic                     ti_start,
  input  logic                     dma_mode,
  input  logic                     cmd_mode,
  input  logic [OFS_W-1:0]         cmd_len,
  input  logic [ID_W-1:0]          bus_id,
  input  logic [NUM_TGT-1:0]       tgt_present,
  input  logic                     sel_start,
  input  logic                     dma_en,
  input  logic signed [PEND_W-1:0] pend_val,
  input  logic                     dev_offer,
  input  logic [LEN_W-1:0]         dev_bytes,
  input  logic                     dma_ack,
  output logic                     dma_req,
  output logic [LEN_W-1:0]         dma_len,
  output logic                     dma_to_dev,
  output logic [OFS_W-1:0]         dma_offset,
  output logic                     cmd_issue,
  output logic                     tc_clear,
  output logic signed [PEND_W-1:0] pend_size,
  output logic [7:0]               status,
  output logic [7:0]               intr_reason,
  output logic [2:0]               seq_step,
  output logic                     irq
);
  logic [LEN_W-1:0] clamp_len;
  logic             clamp_to_dev;
  logic             ev_done, ev_cmd_issue, ev_ti_dma;
  logic             ev_sel_ok, ev_sel_absent, ev_issue;

  assign ev_issue = ev_sel_ok | ev_cmd_issue;

  xfer_clamp #(.CNT_W(CNT_W), .CMD_MAX(CMD_MAX), .LEN_W(LEN_W), .PEND_W(PEND_W)) u_clamp (
    .cnt_raw  ({tc_mid, tc_lo}),
    .cmd_mode (cmd_mode),
    .pend     (pend_size),
    .len      (clamp_len),
    .to_dev   (clamp_to_dev)
  );

  xfer_dma_seq #(.LEN_W(LEN_W), .PEND_W(PEND_W), .CMD_MAX(CMD_MAX), .OFS_W(OFS_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .ti_start     (ti_start),
    .dma_mode     (dma_mode),
    .cmd_mode     (cmd_mode),
    .clamp_len    (clamp_len),
    .clamp_to_dev (clamp_to_dev),
    .cmd_len      (cmd_len),
    .dev_offer    (dev_offer),
    .dev_bytes    (dev_bytes),
    .dma_ack      (dma_ack),
    .pend_load    (ev_issue),
    .pend_val     (pend_val),
    .dma_req      (dma_req),
    .dma_len      (dma_len),
    .dma_to_dev   (dma_to_dev),
    .dma_offset   (dma_offset),
    .pend_q       (pend_size),
    .ev_done      (ev_done),
    .ev_cmd_issue (ev_cmd_issue),
    .ev_ti_dma    (ev_ti_dma)
  );

  xfer_sel_gate #(.NUM_TGT(NUM_TGT), .ID_W(ID_W)) u_sel (
    .clk           (clk),
    .rst_n         (rst_n),
    .sel_start     (sel_start),
    .dma_en        (dma_en),
    .bus_id        (bus_id),
    .tgt_present   (tgt_present),
    .ev_sel_ok     (ev_sel_ok),
    .ev_sel_absent (ev_sel_absent)
  );

  xfer_status #(.PEND_W(PEND_W)) u_stat (
    .clk         (clk),
    .rst_n       (rst_n),
    .ev_ti_dma   (ev_ti_dma),
    .ev_absent   (ev_sel_absent),
    .ev_issue    (ev_issue),
    .issue_val   (pend_val),
    .ev_done     (ev_done),
    .status      (status),
    .intr_reason (intr_reason),
    .seq_step    (seq_step),
    .irq         (irq)
  );

  assign cmd_issue = ev_cmd_issue;
  assign tc_clear  = ev_done;

  // R9: with the enable pin low no selection outcome is produced
  assert_sel_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_en |-> !(ev_sel_ok || ev_sel_absent));

  // R12: status bit 7 tracks the interrupt line
  assert_int_mirror_R12: assert property (@(posedge clk) disable iff (!rst_n)
    status[7] == irq);
endmodule

// File: tb/xfer_ctl_tb.sv
module xfer_ctl_tb;
  localparam int CLK_P = 10;

  logic               clk = 1'b0;
  logic               rst_n;
  logic [7:0]         tc_lo, tc_mid;
  logic               ti_start, dma_mode, cmd_mode;
  logic [5:0]         cmd_len;
  logic [2:0]         bus_id;
  logic [7:0]         tgt_present;
  logic               sel_start, dma_en;
  logic signed [17:0] pend_val;
  logic               dev_offer;
  logic [16:0]        dev_bytes;
  logic               dma_ack;
  logic               dma_req;
  logic [16:0]        dma_len;
  logic               dma_to_dev;
  logic [5:0]         dma_offset;
  logic               cmd_issue, tc_clear;
  logic signed [17:0] pend_size;
  logic [7:0]         status, intr_reason;
  logic [2:0]         seq_step;
  logic               irq;

  int n_checks = 0;
  int n_fail   = 0;
  logic cap_issue, cap_clr;

  always #(CLK_P/2) clk = ~clk;

  xfer_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .tc_lo(tc_lo), .tc_mid(tc_mid),
    .ti_start(ti_start), .dma_mode(dma_mode), .cmd_mode(cmd_mode),
    .cmd_len(cmd_len), .bus_id(bus_id), .tgt_present(tgt_present),
    .sel_start(sel_start), .dma_en(dma_en), .pend_val(pend_val),
    .dev_offer(dev_offer), .dev_bytes(dev_bytes), .dma_ack(dma_ack),
    .dma_req(dma_req), .dma_len(dma_len), .dma_to_dev(dma_to_dev),
    .dma_offset(dma_offset), .cmd_issue(cmd_issue), .tc_clear(tc_clear),
    .pend_size(pend_size), .status(status), .intr_reason(intr_reason),
    .seq_step(seq_step), .irq(irq)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tc_lo = 8'h00; tc_mid = 8'h00; ti_start = 1'b0; dma_mode = 1'b0; cmd_mode = 1'b0;
    cmd_len = '0; bus_id = '0; tgt_present = 8'b0000_0110; sel_start = 1'b0;
    dma_en = 1'b1; pend_val = '0; dev_offer = 1'b0; dev_bytes = '0; dma_ack = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic select(input logic [2:0] id, input int val);
    bus_id = id; pend_val = 18'(val); sel_start = 1'b1;
    @(negedge clk);
    sel_start = 1'b0;
  endtask

  task automatic start_ti(input logic [7:0] lo, input logic [7:0] mid,
                          input logic dma, input logic cmd, input logic [5:0] clen);
    tc_lo = lo; tc_mid = mid; dma_mode = dma; cmd_mode = cmd; cmd_len = clen;
    ti_start = 1'b1;
    #1;
    cap_issue = cmd_issue;
    cap_clr   = tc_clear;
    @(negedge clk);
    ti_start = 1'b0;
  endtask

  task automatic offer(input int n);
    dev_offer = 1'b1; dev_bytes = 17'(n);
    @(negedge clk);
    dev_offer = 1'b0;
  endtask

  task automatic wait_req(input string req);
    bit seen = 1'b0;
    for (int i = 0; i < 50 && !seen; i++) begin
      if (dma_req) seen = 1'b1;
      else @(negedge clk);
    end
    check(req, "request raised", int'(seen), 1);
  endtask

  task automatic ack();
    dma_ack = 1'b1;
    #1;
    cap_issue = cmd_issue;
    cap_clr   = tc_clear;
    @(negedge clk);
    dma_ack = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R12", "status", int'(status), 0);
    check("R12", "reason", int'(intr_reason), 0);
    check("R12", "seq", int'(seq_step), 0);
    check("R12", "pend", int'(pend_size), 0);
    check("R12", "irq", int'(irq), 0);
    check("R12", "dma_req", int'(dma_req), 0);
  endtask

  task automatic t_data_in();
    do_reset();
    select(3'd1, 40);
    check("R10", "status data-in", int'(status), 8'h91);
    check("R10", "reason", int'(intr_reason), 8'h18);
    check("R10", "seq", int'(seq_step), 4);
    check("R10", "pend loaded", int'(pend_size), 40);
    start_ti(8'd24, 8'd0, 1'b1, 1'b0, 6'd0);
    check("R4", "TC cleared", int'(status), 8'h81);
    offer(100);
    wait_req("R3");
    check("R3", "len min(count,pend)", int'(dma_len), 24);
    check("R3", "dir toward host", int'(dma_to_dev), 0);
    ack();
    check("R7", "tc_clear pulse", int'(cap_clr), 1);
    check("R7", "status done", int'(status), 8'h91);
    check("R7", "reason", int'(intr_reason), 8'h10);
    check("R7", "seq", int'(seq_step), 0);
    check("R6", "pend after chunk", int'(pend_size), 16);
    check("R7", "request dropped", int'(dma_req), 0);
  endtask

  task automatic t_data_out_partial();
    do_reset();
    select(3'd2, -30);
    check("R10", "status data-out", int'(status), 8'h90);
    start_ti(8'd0, 8'd1, 1'b1, 1'b0, 6'd0);
    repeat (3) @(negedge clk);
    check("R5", "no request without offer", int'(dma_req), 0);
    offer(10);
    wait_req("R5");
    check("R5", "chunk limited by offer", int'(dma_len), 10);
    check("R3", "dir toward device", int'(dma_to_dev), 1);
    ack();
    check("R5", "no completion yet", int'(cap_clr), 0);
    check("R5", "TC still clear", int'(status), 8'h80);
    check("R6", "pend toward zero", int'(pend_size), -20);
    repeat (2) @(negedge clk);
    check("R5", "waiting for offer", int'(dma_req), 0);
    offer(50);
    wait_req("R5");
    check("R5", "chunk limited by remain", int'(dma_len), 20);
    ack();
    check("R7", "completion", int'(status), 8'h90);
    check("R6", "pend zero", int'(pend_size), 0);
  endtask

  task automatic t_count_zero();
    do_reset();
    select(3'd1, -70000);
    offer(100000);
    start_ti(8'd0, 8'd0, 1'b1, 1'b0, 6'd0);
    wait_req("R1");
    check("R1", "zero count means 65536", int'(dma_len), 65536);
    ack();
    check("R1", "done after full chunk", int'(cap_clr), 1);
    check("R6", "pend after 65536", int'(pend_size), -4464);
  endtask

  task automatic t_cmd_mode();
    do_reset();
    pend_val = 18'sd8;
    start_ti(8'd64, 8'd0, 1'b1, 1'b1, 6'd5);
    wait_req("R2");
    check("R2", "len clamped to 32", int'(dma_len), 32);
    check("R2", "memory read", int'(dma_to_dev), 1);
    check("R2", "offset", int'(dma_offset), 5);
    ack();
    check("R8", "cmd_issue pulse", int'(cap_issue), 1);
    check("R8", "no completion pulse", int'(cap_clr), 0);
    check("R8", "status", int'(status), 8'h91);
    check("R8", "reason", int'(intr_reason), 8'h18);
    check("R8", "seq", int'(seq_step), 4);
    check("R8", "pend loaded", int'(pend_size), 8);
    start_ti(8'd7, 8'd0, 1'b1, 1'b1, 6'd2);
    wait_req("R2");
    check("R2", "len below limit", int'(dma_len), 7);
    ack();
    pend_val = -18'sd3;
    start_ti(8'd7, 8'd0, 1'b0, 1'b1, 6'd0);
    check("R8", "issue without DMA", int'(cap_issue), 1);
    check("R8", "status data-out", int'(status), 8'h90);
    check("R8", "pend", int'(pend_size), -3);
  endtask

  task automatic t_sel_gate();
    do_reset();
    dma_en = 1'b0;
    select(3'd2, 5);
    repeat (3) @(negedge clk);
    check("R9", "held status", int'(status), 0);
    check("R9", "held irq", int'(irq), 0);
    check("R9", "held pend", int'(pend_size), 0);
    dma_en = 1'b1;
    @(negedge clk);
    check("R9", "runs on enable", int'(status), 8'h91);
    check("R9", "pend", int'(pend_size), 5);
  endtask

  task automatic t_absent();
    do_reset();
    select(3'd1, 12);
    check("R10", "present first", int'(status), 8'h91);
    select(3'd5, 12);
    check("R11", "status", int'(status), 8'h80);
    check("R11", "reason", int'(intr_reason), 8'h20);
    check("R11", "seq", int'(seq_step), 0);
    check("R11", "irq", int'(irq), 1);
  endtask

  task automatic t_pio_ignored();
    do_reset();
    select(3'd1, 9);
    start_ti(8'd4, 8'd0, 1'b0, 1'b0, 6'd0);
    check("R4", "no issue", int'(cap_issue), 0);
    repeat (2) @(negedge clk);
    check("R4", "status kept", int'(status), 8'h91);
    check("R4", "no request", int'(dma_req), 0);
    check("R4", "pend kept", int'(pend_size), 9);
  endtask

  task automatic t_zero_len();
    do_reset();
    select(3'd1, 0);
    check("R10", "zero size keeps low status", int'(status), 8'h80);
    check("R10", "reason", int'(intr_reason), 8'h18);
    start_ti(8'd8, 8'd0, 1'b1, 1'b0, 6'd0);
    check("R13", "immediate completion", int'(cap_clr), 1);
    check("R13", "status", int'(status), 8'h90);
    check("R13", "reason", int'(intr_reason), 8'h10);
    repeat (2) @(negedge clk);
    check("R13", "no request", int'(dma_req), 0);
  endtask

  initial begin
    #(CLK_P * 100000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_data_in();
    t_data_out_partial();
    t_count_zero();
    t_cmd_mode();
    t_sel_gate();
    t_absent();
    t_pio_ignored();
    t_zero_len();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule